// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash array. It takes a stream of bus write cycles, each one clock wide, and decodes the unlock-protected command language that guards the array. Every protected command opens with the same two unlock writes. A third write then picks the operation: program, erase set-up, or entry into one of the alternate read modes. An erase needs a second pair of unlock writes, and its sixth write names the sector, the block or the whole chip. Suspend, resume and mode exit can also be given as one write to any address.

Each accepted command leaves the block as a one-clock pulse in the cycle after the write that completes it. A program pulse carries the full word address and data. Sector and block erase pulses carry the sector or block index. The block also holds the current read mode, which the read path uses to choose between array data, identification words, query data and the security area. While the array controller reports an operation in progress, the decoder ignores every write except erase suspend. When write-protect is low, program or erase aimed at the boot block is dropped, and so is chip erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after any reset asserted in the middle of a sequence or in an alternate mode, the decoder is idle, read_mode is 0 (array), and no pulse is high.
- R2: A command prefix is data 0xAA at address 0x555 followed by data 0x55 at address 0x2AA. Only wr_addr[10:0] and wr_data[7:0] are compared, so wr_data[15:8] and the upper address bits have no effect on decoding.
- R3: After the prefix, a write to 0x555 with data 0x90 sets read_mode to 1 (ID), 0x98 sets it to 2 (query), 0x88 sets it to 3 (security ID) and 0xF0 sets it to 0 (array). A lone write of 0xF0 to any address in the idle state also sets read_mode to 0.
- R4: After the prefix and 0xA0 at 0x555, the next write raises prog_pulse for exactly one cycle, in the cycle after that write, with prog_addr and prog_data equal to the full address and data of that write.
- R5: After the prefix, 0x80 at 0x555 and a second prefix, the sixth write raises chip_erase if its data is 0x10 at 0x555, sect_erase with sect_index = wr_addr[21:11] if its data is 0x50, and blk_erase with blk_index = wr_addr[21:15] if its data is 0x30.
- R6: In the idle state, a lone write of 0xB0 to any address raises suspend, and a lone write of 0x30 to any address raises resume.
- R7: A write that does not fit the current step of a sequence, or an unrecognised write while idle, ends the sequence without a pulse and sets read_mode to 0.
- R8: While busy is high, every write except data 0xB0 is ignored: it raises no pulse, leaves read_mode unchanged and does not advance the sequence. A 0xB0 write while busy still raises suspend.
- R9: With wp_n low, program, sector erase and block erase whose address lies in the 32 Kword boot block (address bits 21..15 all zero by default, all one when TOP_BOOT is set) raise no pulse. Chip erase raises no pulse at all. Writes outside the boot block are unaffected.
- R10: At most one of the six action pulses is high in any cycle, and each pulse follows a cycle in which wr_en was high.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Array controller is running a program or erase |
| wp_n | input | 1 | Active-low write protect for the boot block |
| prog_pulse | output | 1 | Program request |
| prog_addr | output | 22 | Address for the program request |
| prog_data | output | 16 | Data for the program request |
| sect_erase | output | 1 | Sector erase request |
| sect_index | output | 11 | Sector to erase |
| blk_erase | output | 1 | Block erase request |
| blk_index | output | 7 | Block to erase |
| chip_erase | output | 1 | Whole-array erase request |
| suspend | output | 1 | Erase suspend request |
| resume | output | 1 | Erase resume request |
| read_mode | output | 2 | 0 array, 1 ID, 2 query, 3 security ID |

## Verification
The decoder is driven with complete unlock sequences for every three-cycle and six-cycle command. It also sees sequences in which the upper data byte or the upper address bits are garbage. If the decoder compares too many bits, these make it reject valid commands. Sequences broken at the second cycle, commands sent while busy, and a 0x55 write after an ignored 0xAA separate a decoder that truly ignores writes from one that only suppresses their pulses. Protected and unprotected targets on either side of the boot block boundary, together with index and payload checks on distinct addresses, expose any wrong bit slice or protection decode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_AW = 11;
  localparam int CMD_DW = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS1, S_ERS2, S_ERS3
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_ID    = 2'd1,
    RM_QUERY = 2'd2,
    RM_SECID = 2'd3
  } read_mode_e;

  localparam logic [CMD_AW-1:0] A_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] A_KEY2 = 11'h2AA;

  localparam logic [CMD_DW-1:0] D_KEY1   = 8'hAA;
  localparam logic [CMD_DW-1:0] D_KEY2   = 8'h55;
  localparam logic [CMD_DW-1:0] C_PROG   = 8'hA0;
  localparam logic [CMD_DW-1:0] C_ERASE  = 8'h80;
  localparam logic [CMD_DW-1:0] C_ID     = 8'h90;
  localparam logic [CMD_DW-1:0] C_QUERY  = 8'h98;
  localparam logic [CMD_DW-1:0] C_SECID  = 8'h88;
  localparam logic [CMD_DW-1:0] C_EXIT   = 8'hF0;
  localparam logic [CMD_DW-1:0] C_SUSP   = 8'hB0;
  localparam logic [CMD_DW-1:0] C_RESUME = 8'h30;
  localparam logic [CMD_DW-1:0] C_CHIP   = 8'h10;
  localparam logic [CMD_DW-1:0] C_SECT   = 8'h50;
  localparam logic [CMD_DW-1:0] C_BLK    = 8'h30;

  // A write matches a key cycle when both the low address and low data agree.
  function automatic logic key_hit(input logic [CMD_AW-1:0] a, input logic [CMD_DW-1:0] d,
                                   input logic [CMD_AW-1:0] ka, input logic [CMD_DW-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  // An operation is dropped when it targets the boot block with protection on.
  function automatic logic wp_blocks(input logic boot_hit, input logic wp_n);
    return boot_hit && !wp_n;
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [CMD_DW-1:0] cmd_data,
  input  logic              busy,
  output logic              ev_prog,
  output logic              ev_sect,
  output logic              ev_blk,
  output logic              ev_chip,
  output logic              ev_susp,
  output logic              ev_resume,
  output logic              ev_mode_set,
  output read_mode_e        ev_mode_val,
  output logic              ev_abort
);

  seq_state_e state_q, state_d;
  logic       take;

  assign take = wr_en && !busy;

  always_comb begin
    state_d     = state_q;
    ev_prog     = 1'b0;
    ev_sect     = 1'b0;
    ev_blk      = 1'b0;
    ev_chip     = 1'b0;
    ev_susp     = 1'b0;
    ev_resume   = 1'b0;
    ev_mode_set = 1'b0;
    ev_mode_val = RM_ARRAY;
    ev_abort    = 1'b0;
    if (wr_en && busy) begin
      ev_susp = (cmd_data == C_SUSP);
    end else if (take) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (key_hit(cmd_addr, cmd_data, A_KEY1, D_KEY1)) state_d = S_UNL1;
          else if (cmd_data == C_SUSP)   ev_susp = 1'b1;
          else if (cmd_data == C_RESUME) ev_resume = 1'b1;
          else if (cmd_data == C_EXIT)   ev_mode_set = 1'b1;
          else                           ev_abort = 1'b1;
        end
        S_UNL1: begin
          if (key_hit(cmd_addr, cmd_data, A_KEY2, D_KEY2)) state_d = S_UNL2;
          else ev_abort = 1'b1;
        end
        S_UNL2: begin
          if (cmd_addr != A_KEY1) ev_abort = 1'b1;
          else begin
            unique case (cmd_data)
              C_PROG:  state_d = S_PROG;
              C_ERASE: state_d = S_ERS1;
              C_ID:    begin ev_mode_set = 1'b1; ev_mode_val = RM_ID;    end
              C_QUERY: begin ev_mode_set = 1'b1; ev_mode_val = RM_QUERY; end
              C_SECID: begin ev_mode_set = 1'b1; ev_mode_val = RM_SECID; end
              C_EXIT:  ev_mode_set = 1'b1;
              default: ev_abort = 1'b1;
            endcase
          end
        end
        S_PROG: ev_prog = 1'b1;
        S_ERS1: begin
          if (key_hit(cmd_addr, cmd_data, A_KEY1, D_KEY1)) state_d = S_ERS2;
          else ev_abort = 1'b1;
        end
        S_ERS2: begin
          if (key_hit(cmd_addr, cmd_data, A_KEY2, D_KEY2)) state_d = S_ERS3;
          else ev_abort = 1'b1;
        end
        S_ERS3: begin
          if (key_hit(cmd_addr, cmd_data, A_KEY1, C_CHIP)) ev_chip = 1'b1;
          else if (cmd_data == C_SECT) ev_sect = 1'b1;
          else if (cmd_data == C_BLK)  ev_blk = 1'b1;
          else                         ev_abort = 1'b1;
        end
        default: ev_abort = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import flash_cmd_pkg::*;
#(
  parameter int BOOT_W   = 7,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              ev_prog,
  input  logic              ev_sect,
  input  logic              ev_blk,
  input  logic              ev_chip,
  input  logic [BOOT_W-1:0] blk_field,
  input  logic              wp_n,
  output logic              ok_prog,
  output logic              ok_sect,
  output logic              ok_blk,
  output logic              ok_chip
);

  logic boot_hit;

  generate
    if (TOP_BOOT) begin : g_top
      assign boot_hit = &blk_field;
    end else begin : g_bottom
      assign boot_hit = ~|blk_field;
    end
  endgenerate

  assign ok_prog = ev_prog && !wp_blocks(boot_hit, wp_n);
  assign ok_sect = ev_sect && !wp_blocks(boot_hit, wp_n);
  assign ok_blk  = ev_blk  && !wp_blocks(boot_hit, wp_n);
  assign ok_chip = ev_chip && wp_n;

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_mode_set,
  input  read_mode_e ev_mode_val,
  input  logic       ev_abort,
  output read_mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= RM_ARRAY;
    else if (ev_abort)    mode_q <= RM_ARRAY;
    else if (ev_mode_set) mode_q <= ev_mode_val;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       busy,
  input  logic                       wp_n,
  output logic                       prog_pulse,
  output logic [ADDR_W-1:0]          prog_addr,
  output logic [DATA_W-1:0]          prog_data,
  output logic                       sect_erase,
  output logic [ADDR_W-SECT_LSB-1:0] sect_index,
  output logic                       blk_erase,
  output logic [ADDR_W-BLK_LSB-1:0]  blk_index,
  output logic                       chip_erase,
  output logic                       suspend,
  output logic                       resume,
  output logic [1:0]                 read_mode
);

  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int BLK_W  = ADDR_W - BLK_LSB;

  logic       ev_prog, ev_sect, ev_blk, ev_chip;
  logic       ev_susp, ev_resume, ev_mode_set, ev_abort;
  read_mode_e ev_mode_val, mode_q;
  logic       ok_prog, ok_sect, ok_blk, ok_chip;

  fcd_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cmd_addr    (wr_addr[CMD_AW-1:0]),
    .cmd_data    (wr_data[CMD_DW-1:0]),
    .busy        (busy),
    .ev_prog     (ev_prog),
    .ev_sect     (ev_sect),
    .ev_blk      (ev_blk),
    .ev_chip     (ev_chip),
    .ev_susp     (ev_susp),
    .ev_resume   (ev_resume),
    .ev_mode_set (ev_mode_set),
    .ev_mode_val (ev_mode_val),
    .ev_abort    (ev_abort)
  );

  fcd_guard #(
    .BOOT_W   (BLK_W),
    .TOP_BOOT (TOP_BOOT)
  ) u_guard (
    .ev_prog   (ev_prog),
    .ev_sect   (ev_sect),
    .ev_blk    (ev_blk),
    .ev_chip   (ev_chip),
    .blk_field (wr_addr[ADDR_W-1:BLK_LSB]),
    .wp_n      (wp_n),
    .ok_prog   (ok_prog),
    .ok_sect   (ok_sect),
    .ok_blk    (ok_blk),
    .ok_chip   (ok_chip)
  );

  fcd_mode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_mode_set (ev_mode_set),
    .ev_mode_val (ev_mode_val),
    .ev_abort    (ev_abort),
    .mode_q      (mode_q)
  );

  assign read_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_pulse <= 1'b0;
      sect_erase <= 1'b0;
      blk_erase  <= 1'b0;
      chip_erase <= 1'b0;
      suspend    <= 1'b0;
      resume     <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      sect_index <= '0;
      blk_index  <= '0;
    end else begin
      prog_pulse <= ok_prog;
      sect_erase <= ok_sect;
      blk_erase  <= ok_blk;
      chip_erase <= ok_chip;
      suspend    <= ev_susp;
      resume     <= ev_resume;
      if (ok_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ok_sect) sect_index <= wr_addr[ADDR_W-1:SECT_LSB];
      if (ok_blk)  blk_index  <= wr_addr[ADDR_W-1:BLK_LSB];
    end
  end

  logic unused_w;
  assign unused_w = ^{SECT_W[0]};

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  parameter bit TOP_BOOT = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       busy,
  input logic                       wp_n,
  input logic                       prog_pulse,
  input logic [ADDR_W-1:0]          prog_addr,
  input logic [DATA_W-1:0]          prog_data,
  input logic                       sect_erase,
  input logic [ADDR_W-SECT_LSB-1:0] sect_index,
  input logic                       blk_erase,
  input logic                       chip_erase,
  input logic                       suspend,
  input logic                       resume,
  input logic [1:0]                 read_mode,
  input logic                       ev_abort
);

  localparam int SECT_W  = ADDR_W - SECT_LSB;
  localparam int BOOT_LO = BLK_LSB - SECT_LSB;

  logic [5:0] pulses;
  logic       sect_in_boot;

  assign pulses       = {prog_pulse, sect_erase, blk_erase, chip_erase, suspend, resume};
  assign sect_in_boot = TOP_BOOT ? (&sect_index[SECT_W-1:BOOT_LO])
                                 : !(|sect_index[SECT_W-1:BOOT_LO]);

  // R10
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  // R10
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past(wr_en));

  // R4
  prog_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (prog_addr == $past(wr_addr)) && (prog_data == $past(wr_data)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_data[7:0] != 8'hB0) |=> (pulses == 6'b0) && $stable(read_mode));

  // R9
  chip_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase |-> $past(wp_n));

  // R9
  sect_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_erase && !$past(wp_n)) |-> !sect_in_boot);

  // R6
  suspend_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> ($past(wr_data[7:0]) == 8'hB0));

  // R7
  abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (read_mode == 2'd0));

endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SECT_LSB (SECT_LSB),
  .BLK_LSB  (BLK_LSB),
  .TOP_BOOT (TOP_BOOT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .busy       (busy),
  .wp_n       (wp_n),
  .prog_pulse (prog_pulse),
  .prog_addr  (prog_addr),
  .prog_data  (prog_data),
  .sect_erase (sect_erase),
  .sect_index (sect_index),
  .blk_erase  (blk_erase),
  .chip_erase (chip_erase),
  .suspend    (suspend),
  .resume     (resume),
  .read_mode  (read_mode),
  .ev_abort   (ev_abort)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [21:0] wr_addr;
  logic [15:0] wr_data;
  logic        busy;
  logic        wp_n;
  logic        prog_pulse, sect_erase, blk_erase, chip_erase, suspend, resume;
  logic [21:0] prog_addr;
  logic [15:0] prog_data;
  logic [10:0] sect_index;
  logic [6:0]  blk_index;
  logic [1:0]  read_mode;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [5:0]  cap_pulse;
  logic [1:0]  cap_mode;
  logic [51:0] vec_q;

  always #5 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .wp_n(wp_n), .prog_pulse(prog_pulse), .prog_addr(prog_addr),
    .prog_data(prog_data), .sect_erase(sect_erase), .sect_index(sect_index),
    .blk_erase(blk_erase), .blk_index(blk_index), .chip_erase(chip_erase),
    .suspend(suspend), .resume(resume), .read_mode(read_mode)
  );

  // pulse field order {prog, sect, blk, chip, suspend, resume}
  // fields: addr[51:30] data[29:14] busy[13] wp_n[12] pulses[11:6] mode[5:4] req[3:0]
  localparam int NV = 62;
  localparam logic [51:0] VEC [NV] = '{
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd2},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd2},
    {22'h000555, 16'h0090, 1'b0, 1'b1, 6'b000000, 2'd1, 4'd3},
    {22'h000123, 16'h00F0, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h000555, 16'h12AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd2},
    {22'h0002AA, 16'h3455, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd2},
    {22'h000555, 16'h0098, 1'b0, 1'b1, 6'b000000, 2'd2, 4'd3},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd2, 4'd3},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd2, 4'd3},
    {22'h000555, 16'h00F0, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h000555, 16'h0088, 1'b0, 1'b1, 6'b000000, 2'd3, 4'd3},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd3, 4'd7},
    {22'h0002AA, 16'h0066, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd7},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd4},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd4},
    {22'h000555, 16'h00A0, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd4},
    {22'h012345, 16'hBEEF, 1'b0, 1'b1, 6'b100000, 2'd0, 4'd4},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h0080, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0A5800, 16'hFF50, 1'b0, 1'b1, 6'b010000, 2'd0, 4'd5},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h0080, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h3F8000, 16'h0030, 1'b0, 1'b1, 6'b001000, 2'd0, 4'd5},
    {22'h3FF555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd2},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h0080, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd5},
    {22'h3FF555, 16'h0010, 1'b0, 1'b1, 6'b000100, 2'd0, 4'd5},
    {22'h000000, 16'h00B0, 1'b1, 1'b1, 6'b000010, 2'd0, 4'd6},
    {22'h000555, 16'h00AA, 1'b1, 1'b1, 6'b000000, 2'd0, 4'd8},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd8},
    {22'h000000, 16'h0030, 1'b0, 1'b1, 6'b000001, 2'd0, 4'd6},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h000555, 16'h0090, 1'b0, 1'b1, 6'b000000, 2'd1, 4'd3},
    {22'h0000F0, 16'h00F0, 1'b1, 1'b1, 6'b000000, 2'd1, 4'd8},
    {22'h0000F0, 16'h00F0, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd3},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h00A0, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000100, 16'h1234, 1'b0, 1'b0, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h0080, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h0010, 1'b0, 1'b0, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h0080, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h000555, 16'h00AA, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h0002AA, 16'h0055, 1'b0, 1'b1, 6'b000000, 2'd0, 4'd9},
    {22'h001000, 16'h0030, 1'b0, 1'b0, 6'b000000, 2'd0, 4'd9}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drives one write, captures the outputs one clock after the write edge.
  task automatic do_write(input logic [21:0] a, input logic [15:0] d,
                          input logic b, input logic w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b; wp_n = w;
    @(posedge clk);
    #1;
    cap_pulse = {prog_pulse, sect_erase, blk_erase, chip_erase, suspend, resume};
    cap_mode  = read_mode;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0; wp_n = 1'b1;
  endtask

  task automatic erase_prefix;
    do_write(22'h000555, 16'h00AA, 1'b0, 1'b1);
    do_write(22'h0002AA, 16'h0055, 1'b0, 1'b1);
    do_write(22'h000555, 16'h0080, 1'b0, 1'b1);
    do_write(22'h000555, 16'h00AA, 1'b0, 1'b1);
    do_write(22'h0002AA, 16'h0055, 1'b0, 1'b1);
  endtask

  task automatic prog_prefix;
    do_write(22'h000555, 16'h00AA, 1'b0, 1'b1);
    do_write(22'h0002AA, 16'h0055, 1'b0, 1'b1);
    do_write(22'h000555, 16'h00A0, 1'b0, 1'b1);
  endtask

  task automatic pulse_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; wp_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {26'b0, prog_pulse, sect_erase, blk_erase, chip_erase, suspend, resume}, 32'h0);
    check("R1", {30'b0, read_mode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_q = VEC[i];
      do_write(vec_q[51:30], vec_q[29:14], vec_q[13], vec_q[12]);
      checks++;
      if ({cap_pulse, cap_mode} !== vec_q[11:4]) begin
        errs++;
        $display("FAIL %s: vector %0d actual pulses=%b mode=%0d expected pulses=%b mode=%0d",
                 tag(vec_q[3:0]), i, cap_pulse, cap_mode, vec_q[11:6], vec_q[5:4]);
      end
    end

    // R4 payload and one-cycle width
    prog_prefix();
    do_write(22'h2ABCDE, 16'hC3A5, 1'b0, 1'b1);
    check("R4", {31'b0, cap_pulse[5]}, 32'd1);
    check("R4", {10'b0, prog_addr}, 32'h2ABCDE);
    check("R4", {16'b0, prog_data}, 32'hC3A5);
    @(posedge clk); #1;
    check("R4", {31'b0, prog_pulse}, 32'd0);

    // R5 sector and block index
    erase_prefix();
    do_write(22'h1A5C00, 16'h0050, 1'b0, 1'b1);
    check("R5", {26'b0, cap_pulse}, 32'b010000);
    check("R5", {21'b0, sect_index}, 32'h1A5C00 >> 11);
    erase_prefix();
    do_write(22'h2C4321, 16'h0030, 1'b0, 1'b1);
    check("R5", {26'b0, cap_pulse}, 32'b001000);
    check("R5", {25'b0, blk_index}, 32'h2C4321 >> 15);

    // R9 boot block edges with protection on
    erase_prefix();
    do_write(22'h007800, 16'h0050, 1'b0, 1'b0);
    check("R9", {26'b0, cap_pulse}, 32'b0);
    erase_prefix();
    do_write(22'h200000, 16'h0050, 1'b0, 1'b0);
    check("R9", {26'b0, cap_pulse}, 32'b010000);
    prog_prefix();
    do_write(22'h008000, 16'h5678, 1'b0, 1'b0);
    check("R9", {26'b0, cap_pulse}, 32'b100000);
    check("R9", {10'b0, prog_addr}, 32'h008000);

    // R1 reset mid-sequence: the 0x90 alone must not enter ID mode
    do_write(22'h000555, 16'h00AA, 1'b0, 1'b1);
    do_write(22'h0002AA, 16'h0055, 1'b0, 1'b1);
    pulse_reset();
    do_write(22'h000555, 16'h0090, 1'b0, 1'b1);
    check("R1", {30'b0, cap_mode}, 32'd0);

    // R1 reset from ID mode
    do_write(22'h000555, 16'h00AA, 1'b0, 1'b1);
    do_write(22'h0002AA, 16'h0055, 1'b0, 1'b1);
    do_write(22'h000555, 16'h0090, 1'b0, 1'b1);
    check("R3", {30'b0, cap_mode}, 32'd1);
    pulse_reset();
    #1;
    check("R1", {30'b0, read_mode}, 32'd0);

    // R10 pulses stay low with no write
    repeat (3) @(posedge clk);
    #1;
    check("R10", {26'b0, prog_pulse, sect_erase, blk_erase, chip_erase, suspend, resume}, 32'h0);

    finished = 1'b1;
    finish_run();
  end

endmodule